// File: doc/BRIEF.md
# Real-Time Clock Counter Controller

This block keeps time of day as seconds, minutes and hours. A 256 Hz tick pulse from an external prescaler drives it. An internal sub-second counter turns every 256 ticks into one second event. A 16-bit control word sets the following: counting on or off, a software reset of the sub-second phase, 24-hour or 12-hour display, a request to round the time to the nearest minute, and a hold that freezes the time fields so software can read them coherently.

If a second event arrives while hold is set, it is remembered. The missed second is added as soon as hold is released. Every change of the time (normal count, late correction or rounding) raises a count-busy status for one tick period. Writing the trim byte of the control word raises a trim-busy status, which drops at the next second boundary; the trim arithmetic itself lies outside this block. A seconds flag and a minutes flag, each with its own enable, are ORed onto one interrupt line.

Software talks to the block through a write port with byte strobes and a combinational read port over four word addresses: control (0), minutes and seconds (1), hours (2), and interrupt flags and enables (3).

Top module: `rtc_counter_ctrl`

## Requirements
- R1: After reset every readable word is 0x0000 and `irq` is 0.
- R2: The control word reads as {trim_busy[15], zeros[14:7], count_busy[6], hold[5], mode24[4], 0[3], adjust[2], swreset[1], run[0]`}`. Reserved bits 7 and 3 and the trim bits 14..8 always read 0. Bits 15 and 6 cannot be written.
- R3: With run=1 and swreset=0, the 256th tick after the sub-second counter was at zero adds one second, and earlier ticks change nothing. With run=0, ticks have no effect.
- R4: In 24-hour mode (bit 4 = 1), seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0. Address 1 holds minutes in bits 13..8 and seconds in bits 5..0. Address 2 holds hours in bits 4..0 and the PM bit in bit 7.
- R5: In 12-hour mode (bit 4 = 0), hours advance 12, 1, 2, up to 11 and then 12 again. The PM bit toggles on the change from 11 to 12.
- R6: count_busy goes to 1 on the clock edge where the time is advanced or rounded. It stays at 1 until the next tick, which clears it.
- R7: While hold is 1, the time fields do not change, and no seconds flag is raised. A second boundary passed during hold adds exactly one second on the clock edge after hold is cleared. A hold with no boundary in it adds nothing.
- R8: Writing adjust=1 rounds the time on the clock edge after the write, then adjust reads 0. Seconds below 30 become 0 with the minutes unchanged. Seconds of 30 or more become 0 and carry one minute.
- R9: A control write with swreset=1 clears hold and adjust. While swreset is 1, the sub-second counter is held at zero, so a full 256 ticks are needed after swreset is cleared.
- R10: A write with the upper byte strobe to address 0 sets trim_busy. trim_busy clears by itself on the next second boundary.
- R11: Address 3 holds the flags in bits 1..0 (bit 0 seconds, bit 1 minutes) and the enables in bits 9..8. Each count or rounding that changes the time sets the seconds flag, except a rounding alone. A change of minutes sets the minutes flag. Writing 1 with the lower strobe clears a flag. `irq` is 1 only while some flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_256 | input | 1 | One-cycle pulse at 256 Hz from the prescaler |
| wr_en | input | 1 | Write request |
| wr_addr | input | 2 | Write word address |
| wr_strb | input | 2 | Byte strobes: bit 0 low byte, bit 1 high byte |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 16 | Read data for rd_addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
Several rules are checked by assertions on every cycle:

- The time fields stay frozen whenever hold is set and no software write is loading them.
- count_busy is never dropped except by a tick.
- A rising seconds flag always comes with count_busy.
- trim_busy falls only after a second boundary.
- swreset always leaves hold and adjust at zero.

The bench scenarios cover the rest:

- The arithmetic of the rollovers in both hour modes.
- Rounding below and above 30 seconds.
- The single late second after a hold.
- The fresh 256-tick phase after swreset.
- The interrupt gating by the enables.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int N_IRQ  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_MS   = 2'd1,
        A_HR   = 2'd2,
        A_IRQ  = 2'd3
    } addr_e;

    typedef struct packed {
        logic hold;
        logic mode24;
        logic adj;
        logic rst;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic       pm;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } time_t;

    function automatic time_t hour_step(time_t t, logic m24);
        time_t r = t;
        if (m24) begin
            r.hour = (t.hour >= 5'd23) ? 5'd0 : t.hour + 5'd1;
        end else if (t.hour == 5'd11) begin
            r.hour = 5'd12;
            r.pm   = ~t.pm;
        end else if (t.hour >= 5'd12) begin
            r.hour = 5'd1;
        end else begin
            r.hour = t.hour + 5'd1;
        end
        return r;
    endfunction

    function automatic time_t minute_step(time_t t, logic m24);
        time_t r = t;
        if (t.min >= 6'd59) begin
            r.min = 6'd0;
            r = hour_step(r, m24);
        end else begin
            r.min = t.min + 6'd1;
        end
        return r;
    endfunction

    function automatic time_t second_step(time_t t, logic m24);
        time_t r = t;
        if (t.sec >= 6'd59) begin
            r.sec = 6'd0;
            r = minute_step(r, m24);
        end else begin
            r.sec = t.sec + 6'd1;
        end
        return r;
    endfunction

    function automatic time_t round_half_minute(time_t t, logic m24);
        time_t r = t;
        r.sec = 6'd0;
        if (t.sec >= 6'd30) r = minute_step(r, m24);
        return r;
    endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_lo,
    input  logic  wr_hi,
    input  ctrl_t wr_val,
    input  logic  adj_done,
    input  logic  sec_event,
    output ctrl_t ctrl_q,
    output logic  trim_busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_lo) begin
            ctrl_q.run    <= wr_val.run;
            ctrl_q.rst    <= wr_val.rst;
            ctrl_q.mode24 <= wr_val.mode24;
            ctrl_q.hold   <= wr_val.hold & ~wr_val.rst;
            ctrl_q.adj    <= wr_val.adj & ~wr_val.rst;
        end else if (adj_done) begin
            ctrl_q.adj <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_busy <= 1'b0;
        end else if (wr_hi && !trim_busy) begin
            trim_busy <= 1'b1;
        end else if (sec_event) begin
            trim_busy <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int SUB_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  ctrl_t      ctrl,
    input  logic       wr_ms_lo,
    input  logic       wr_ms_hi,
    input  logic       wr_hr_lo,
    input  logic [5:0] sec_wr,
    input  logic [5:0] min_wr,
    input  logic [4:0] hour_wr,
    input  logic       pm_wr,
    output time_t      tm,
    output logic       busy,
    output logic       sec_event,
    output logic       inc_pulse,
    output logic       min_pulse,
    output logic       adj_done
);

    logic [SUB_W-1:0] sub_q;
    logic             pend_q;
    time_t            stepped;
    time_t            nxt;

    assign sec_event = tick & ctrl.run & ~ctrl.rst & (&sub_q);
    assign inc_pulse = (sec_event | pend_q) & ~ctrl.hold;
    assign adj_done  = ctrl.adj & ~ctrl.hold & ~inc_pulse;
    assign min_pulse = (inc_pulse | adj_done) & (stepped.min != tm.min);

    always_comb begin
        if (inc_pulse)
            stepped = second_step(tm, ctrl.mode24);
        else if (adj_done)
            stepped = round_half_minute(tm, ctrl.mode24);
        else
            stepped = tm;
        nxt = stepped;
        if (wr_ms_lo) nxt.sec = sec_wr;
        if (wr_ms_hi) nxt.min = min_wr;
        if (wr_hr_lo) begin
            nxt.hour = hour_wr;
            nxt.pm   = pm_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl.rst)
            sub_q <= '0;
        else if (tick && ctrl.run)
            sub_q <= sub_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl.rst)
            pend_q <= 1'b0;
        else if (ctrl.hold)
            pend_q <= pend_q | sec_event;
        else
            pend_q <= pend_q & sec_event;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm   <= '0;
            busy <= 1'b0;
        end else begin
            tm <= nxt;
            if (inc_pulse || adj_done)
                busy <= 1'b1;
            else if (tick)
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] set_i,
    input  logic             clr_wr,
    input  logic [N_IRQ-1:0] clr_bits,
    input  logic             en_wr,
    input  logic [N_IRQ-1:0] en_bits,
    output logic [N_IRQ-1:0] flags,
    output logic [N_IRQ-1:0] en_q,
    output logic             irq
);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)
                f_q <= 1'b0;
            else if (set_i[i])
                f_q <= 1'b1;
            else if (clr_wr && clr_bits[i])
                f_q <= 1'b0;
        end
        assign flags[i] = f_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (en_wr)
            en_q <= en_bits;
    end

    assign irq = |(flags & en_q);

endmodule

// File: rtl/rtc_counter_ctrl.sv
module rtc_counter_ctrl
    import rtc_pkg::*;
#(
    parameter int SUB_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_256,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_strb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int PAD_W = 8 - N_IRQ;

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_wr;
    time_t            tm;
    logic             trim_busy;
    logic             cnt_busy;
    logic             sec_event;
    logic             inc_pulse;
    logic             min_pulse;
    logic             adj_done;
    logic [N_IRQ-1:0] irq_flags;
    logic [N_IRQ-1:0] irq_en;
    logic             wr_ctrl_lo, wr_ctrl_hi, wr_ms_lo, wr_ms_hi, wr_hr_lo;
    logic             wr_irq_lo, wr_irq_hi;
    logic             unused_bits;

    assign wr_ctrl_lo = wr_en && (wr_addr == A_CTRL) && wr_strb[0];
    assign wr_ctrl_hi = wr_en && (wr_addr == A_CTRL) && wr_strb[1];
    assign wr_ms_lo   = wr_en && (wr_addr == A_MS)   && wr_strb[0];
    assign wr_ms_hi   = wr_en && (wr_addr == A_MS)   && wr_strb[1];
    assign wr_hr_lo   = wr_en && (wr_addr == A_HR)   && wr_strb[0];
    assign wr_irq_lo  = wr_en && (wr_addr == A_IRQ)  && wr_strb[0];
    assign wr_irq_hi  = wr_en && (wr_addr == A_IRQ)  && wr_strb[1];

    assign ctrl_wr.run    = wr_data[0];
    assign ctrl_wr.rst    = wr_data[1];
    assign ctrl_wr.adj    = wr_data[2];
    assign ctrl_wr.mode24 = wr_data[4];
    assign ctrl_wr.hold   = wr_data[5];
    assign unused_bits    = ^{wr_data[15:14], wr_data[6]};

    rtc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_lo     (wr_ctrl_lo),
        .wr_hi     (wr_ctrl_hi),
        .wr_val    (ctrl_wr),
        .adj_done  (adj_done),
        .sec_event (sec_event),
        .ctrl_q    (ctrl_q),
        .trim_busy (trim_busy)
    );

    rtc_time_core #(.SUB_W(SUB_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_256),
        .ctrl      (ctrl_q),
        .wr_ms_lo  (wr_ms_lo),
        .wr_ms_hi  (wr_ms_hi),
        .wr_hr_lo  (wr_hr_lo),
        .sec_wr    (wr_data[5:0]),
        .min_wr    (wr_data[13:8]),
        .hour_wr   (wr_data[4:0]),
        .pm_wr     (wr_data[7]),
        .tm        (tm),
        .busy      (cnt_busy),
        .sec_event (sec_event),
        .inc_pulse (inc_pulse),
        .min_pulse (min_pulse),
        .adj_done  (adj_done)
    );

    rtc_irq_unit u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_i    ({min_pulse, inc_pulse}),
        .clr_wr   (wr_irq_lo),
        .clr_bits (wr_data[N_IRQ-1:0]),
        .en_wr    (wr_irq_hi),
        .en_bits  (wr_data[8 +: N_IRQ]),
        .flags    (irq_flags),
        .en_q     (irq_en),
        .irq      (irq)
    );

    always_comb begin
        case (addr_e'(rd_addr))
            A_CTRL:  rd_data = {trim_busy, 7'd0, 1'b0, cnt_busy, ctrl_q.hold,
                                ctrl_q.mode24, 1'b0, ctrl_q.adj, ctrl_q.rst, ctrl_q.run};
            A_MS:    rd_data = {2'd0, tm.min, 2'd0, tm.sec};
            A_HR:    rd_data = {8'd0, tm.pm, 2'd0, tm.hour};
            default: rd_data = {{PAD_W{1'b0}}, irq_en, {PAD_W{1'b0}}, irq_flags};
        endcase
    end

endmodule

// File: rtl/rtc_counter_ctrl_chk.sv
module rtc_counter_ctrl_chk
    import rtc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  tick,
    input logic  hold,
    input logic  adj,
    input logic  ctrl_rst,
    input logic  busy,
    input logic  trim_busy,
    input logic  sec_event,
    input logic  sec_flag,
    input time_t tm,
    input logic  tm_wr
);

    // R7: frozen time while held
    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && !tm_wr) |=> $stable(tm));

    // R6: only a tick ends the busy window
    assert_busy_until_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);

    // R11: the seconds flag rises together with a count-up
    assert_flag_with_busy_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_flag) |-> busy);

    // R10: trim-busy drops only after a second boundary
    assert_trim_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(trim_busy) |-> $past(sec_event));

    // R9: software reset leaves hold and adjust cleared
    assert_swreset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_rst |-> (!hold && !adj));

endmodule

bind rtc_counter_ctrl rtc_counter_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_256),
    .hold      (ctrl_q.hold),
    .adj       (ctrl_q.adj),
    .ctrl_rst  (ctrl_q.rst),
    .busy      (cnt_busy),
    .trim_busy (trim_busy),
    .sec_event (sec_event),
    .sec_flag  (irq_flags[0]),
    .tm        (tm),
    .tm_wr     (wr_ms_lo | wr_ms_hi | wr_hr_lo)
);

// File: tb/rtc_counter_ctrl_tb.sv
module rtc_counter_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_256 = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [1:0]  wr_strb = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int e_sec, e_min, e_hr, e_sub;
    bit e_pm, e_m24, e_run, e_rst, e_hold, e_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_counter_ctrl u_dut (
        .clk(clk), .rst(rst), .tick_256(tick_256), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #2;
        v = rd_data;
    endtask

    task automatic chk_rd(string tag, logic [1:0] a, logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] s, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic advance();
        int idx, tot, om;
        om  = e_min;
        idx = e_m24 ? e_hr : (e_hr % 12) + (e_pm ? 12 : 0);
        tot = (idx * 3600 + e_min * 60 + e_sec + 1) % 86400;
        idx = tot / 3600;
        e_min = (tot / 60) % 60;
        e_sec = tot % 60;
        if (e_m24) e_hr = idx;
        else begin
            e_hr = (idx % 12 == 0) ? 12 : idx % 12;
            e_pm = (idx >= 12);
        end
        if (e_min == om) e_min = e_min;
    endtask

    task automatic ticks(int n);
        tick_256 = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick_256 = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (e_run && !e_rst) begin
                if (e_sub == 255) begin
                    e_sub = 0;
                    if (e_hold) e_pend = 1;
                    else advance();
                end else e_sub++;
            end
        end
    endtask

    task automatic next_sec();
        ticks(256 - e_sub);
    endtask

    task automatic set_ctrl(logic [15:0] d);
        wr(2'd0, 2'b01, d);
        e_run = d[0]; e_rst = d[1]; e_m24 = d[4];
        e_hold = d[5] & ~d[1];
        if (e_rst) begin e_sub = 0; e_pend = 0; end
    endtask

    task automatic set_time(int h, int m, int s, bit pm);
        wr(2'd1, 2'b11, {2'b0, 6'(m), 2'b0, 6'(s)});
        wr(2'd2, 2'b01, {8'b0, pm, 2'b0, 5'(h)});
        e_hr = h; e_min = m; e_sec = s; e_pm = pm;
    endtask

    task automatic chk_time(string tag);
        chk_rd({tag, " min/sec"}, 2'd1, {2'b0, 6'(e_min), 2'b0, 6'(e_sec)});
        chk_rd({tag, " hour"}, 2'd2, {8'b0, e_pm, 2'b0, 5'(e_hr)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        e_sec = 0; e_min = 0; e_hr = 0; e_sub = 0;
        e_pm = 0; e_m24 = 0; e_run = 0; e_rst = 0; e_hold = 0; e_pend = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) chk_rd("R1 reset word", 2'(a), 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);

        // R3 basic counting
        set_ctrl(16'h0011);
        wr(2'd3, 2'b10, 16'h0100);
        ticks(255);
        chk_time("R3 before 256th tick");
        chk_rd("R11 no flag yet", 2'd3, 16'h0100);
        ticks(1);
        chk_time("R3 after 256th tick");
        chk_rd("R11 sec flag", 2'd3, 16'h0101);
        chk("R11 irq enabled", {15'b0, irq}, 16'h0001);
        chk_rd("R6 busy set", 2'd0, 16'h0051);
        idle(3);
        chk_rd("R6 busy held without tick", 2'd0, 16'h0051);
        ticks(1);
        chk_rd("R6 busy cleared by tick", 2'd0, 16'h0011);

        // R11 clear and gating
        wr(2'd3, 2'b01, 16'h0001);
        chk_rd("R11 flag cleared", 2'd3, 16'h0100);
        chk("R11 irq after clear", {15'b0, irq}, 16'h0000);
        wr(2'd3, 2'b10, 16'h0000);
        next_sec();
        chk_rd("R11 flag disabled", 2'd3, 16'h0001);
        chk("R11 irq masked", {15'b0, irq}, 16'h0000);
        wr(2'd3, 2'b01, 16'h0003);
        ticks(1);

        // R2 layout, R10 trim busy
        set_ctrl(16'h00D9);
        chk_rd("R2 reserved and read-only bits", 2'd0, 16'h0011);
        wr(2'd0, 2'b10, 16'h7F00);
        chk_rd("R10 trim busy set, R2 trim reads 0", 2'd0, 16'h8011);
        set_ctrl(16'h0010);
        ticks(300);
        chk_time("R3 stopped when run=0");
        chk_rd("R10 trim busy waits", 2'd0, 16'h8010);
        set_ctrl(16'h0011);
        ticks(255 - e_sub);
        chk_rd("R10 trim busy before boundary", 2'd0, 16'h8011);
        ticks(1);
        chk_rd("R10 trim busy cleared at boundary", 2'd0, 16'h0051);
        chk_time("R3 resumed");
        ticks(1);

        // R4 24-hour rollover
        set_time(23, 59, 58, 0);
        wr(2'd3, 2'b01, 16'h0003);
        next_sec(); next_sec();
        chk_time("R4 midnight wrap");
        chk_rd("R11 min flag", 2'd3, 16'h0003);

        // R5 12-hour sequence
        set_ctrl(16'h0001);
        set_time(11, 59, 59, 0);
        next_sec();
        chk_time("R5 11 to 12 am->pm");
        set_time(12, 59, 59, 1);
        next_sec();
        chk_time("R5 12 to 1");
        set_time(11, 59, 59, 1);
        next_sec();
        chk_time("R5 11 to 12 pm->am");

        // R7 hold and late second
        set_ctrl(16'h0011);
        set_time(4, 20, 10, 0);
        next_sec();
        ticks(1);
        wr(2'd3, 2'b01, 16'h0003);
        set_ctrl(16'h0031);
        ticks(256);
        chk_time("R7 frozen in hold");
        chk_rd("R7 no flag in hold", 2'd3, 16'h0000);
        chk_rd("R7 no busy in hold", 2'd0, 16'h0031);
        set_ctrl(16'h0011);
        chk_time("R7 not yet corrected");
        idle(1);
        e_pend = 0;
        advance();
        chk_time("R7 late second applied");
        chk_rd("R7 correction busy", 2'd0, 16'h0051);
        chk_rd("R7 correction flag", 2'd3, 16'h0001);
        idle(2);
        chk_time("R7 single correction");
        ticks(1);
        set_ctrl(16'h0031);
        ticks(10);
        set_ctrl(16'h0011);
        idle(2);
        chk_time("R7 hold without boundary adds nothing");

        // R8 adjust rounding
        set_time(7, 10, 29, 0);
        set_ctrl(16'h0015);
        chk_rd("R8 adjust pending", 2'd0, 16'h0015);
        idle(1);
        e_sec = 0;
        chk_time("R8 round down");
        chk_rd("R8 adjust cleared, busy set", 2'd0, 16'h0051);
        ticks(1);
        set_time(5, 59, 30, 0);
        wr(2'd3, 2'b01, 16'h0003);
        set_ctrl(16'h0015);
        idle(1);
        e_hr = 6; e_min = 0; e_sec = 0;
        chk_time("R8 round up with carry");
        chk_rd("R11 min flag from rounding", 2'd3, 16'h0002);

        // R9 software reset
        ticks(1);
        set_ctrl(16'h0037);
        chk_rd("R9 hold and adjust cleared", 2'd0, 16'h0013);
        idle(2);
        chk_time("R9 no rounding after swreset");
        ticks(300);
        chk_time("R9 held phase");
        set_ctrl(16'h0011);
        ticks(255);
        chk_time("R9 fresh phase 255 ticks");
        ticks(1);
        chk_time("R9 fresh phase 256 ticks");

        // random sequences (R4, R5)
        for (int it = 0; it < 40; it++) begin
            bit m24;
            int h;
            m24 = 1'($urandom % 2);
            set_ctrl(m24 ? 16'h0011 : 16'h0001);
            h = m24 ? int'($urandom % 24) : 1 + int'($urandom % 12);
            set_time(h, 50 + int'($urandom % 10), 50 + int'($urandom % 10),
                     1'($urandom % 2));
            ticks(1 + int'($urandom % 700));
            chk_time(m24 ? "R4 random" : "R5 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule